// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block passes an 18-bit word between two buses in both directions, A to B and B to A. Each direction has its own storage word. Each direction can run in one of three ways. In pass-through mode the output follows the input with no register in between. In hold mode the stored word sits still while its bus clock is static. In clocked mode a rising edge of the bus clock loads the input into the store, and only while an active-low clock-enable is low. An active-low output enable on each direction sets the drive-enable of the side that direction feeds. A wrapper built around the block can turn the data outputs and drive-enables into tri-state pins.

Each direction has its own set of controls, and the two directions never share state. Everything runs on one free-running system clock. The bus clocks are synchronised to it and their rising edges are detected there. Transparency is a combinational bypass multiplexer in front of the output, so no real latch is built.

Top module: `ubt_transceiver`

## Requirements
- R1: While reset is asserted, and after it is released with no activity, both stored words are zero. With the latch-enable low, both data outputs therefore read zero.
- R2: While a latch-enable (`le_ab` or `le_ba`) is high, the output of that direction equals its input in the same cycle, with no clock delay.
- R3: While the latch-enable is low and the bus clock does not rise, the output keeps the stored word whatever the input does.
- R4: With the latch-enable low and the clock-enable low (enabled), a rising edge of the bus clock loads the input into the store. The new word appears on the output within SYNC_STAGES+1 system clocks of the edge.
- R5: A rising bus clock edge while the clock-enable is high is ignored, and the stored word is unchanged.
- R6: While the latch-enable is high, the store follows the input on every system clock. After the latch-enable falls, the output keeps the last word that was passed through.
- R7: The output enable is active low. The drive-enable of the side a direction feeds is 1 when that output enable is 0, and 0 when it is 1 (high impedance).
- R8: The store keeps updating while the output enable is high. When the output is enabled again, it shows the current stored word.
- R9: The two directions are independent. An operation on one direction never changes the output of the other.
- R10: A falling edge of a bus clock never changes the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | Word received from the A bus |
| b_in | input | 18 | Word received from the B bus |
| le_ab | input | 1 | A-to-B pass-through enable, high = transparent |
| clk_ab | input | 1 | A-to-B bus clock, rising edge loads |
| ce_ab_n | input | 1 | A-to-B clock-enable, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ba | input | 1 | B-to-A pass-through enable, high = transparent |
| clk_ba | input | 1 | B-to-A bus clock, rising edge loads |
| ce_ba_n | input | 1 | B-to-A clock-enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word driven onto the B bus |
| b_drive | output | 1 | B-side drive-enable, 0 = high impedance |
| a_out | output | 18 | Word driven onto the A bus |
| a_drive | output | 1 | A-side drive-enable, 0 = high impedance |

## Verification
The assertions assume that each bus clock is slow compared with the system clock. Each of its levels must last at least SYNC_STAGES+1 system cycles, so that every rise gives exactly one detected edge. They also assume that the data word and the clock-enable stay steady from before a bus clock rises until the edge has been detected. The stimulus, random and directed alike, drives inputs on the falling system clock. It holds every bus clock level and every data change for six system cycles, which keeps all of it within those assumptions, and it keeps both bus clocks low through reset.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int UBT_WIDTH = 18;
  localparam int UBT_SYNC  = 2;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_PASS    = 2'd1,
    ACT_CAPTURE = 2'd2,
    ACT_SKIP    = 2'd3
  } ubt_action_e;
endpackage

// File: rtl/ubt_rise_detect.sv
module ubt_rise_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  // R4: a detected rise is a single-cycle pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ubt_path.sv
module ubt_path
  import ubt_pkg::*;
#(
  parameter int W      = UBT_WIDTH,
  parameter int STAGES = UBT_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         bclk,
  input  logic         ce_n,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         drive
);
  logic         bclk_rise;
  logic [W-1:0] store_q;
  ubt_action_e  action;

  ubt_rise_detect #(.STAGES(STAGES)) u_rise (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (bclk),
    .rise     (bclk_rise)
  );

  function automatic ubt_action_e pick_action(input logic open_l,
                                              input logic edge_seen,
                                              input logic gate_n);
    if (open_l)         return ACT_PASS;
    else if (!edge_seen) return ACT_HOLD;
    else if (!gate_n)   return ACT_CAPTURE;
    else                return ACT_SKIP;
  endfunction

  function automatic logic [W-1:0] out_word(input logic open_l,
                                            input logic [W-1:0] live,
                                            input logic [W-1:0] kept);
    return open_l ? live : kept;
  endfunction

  assign action = pick_action(le, bclk_rise, ce_n);

  always_ff @(posedge clk) begin
    if (!rst_n) store_q <= '0;
    else if (action == ACT_PASS || action == ACT_CAPTURE) store_q <= din;
  end

  assign dout  = out_word(le, din, store_q);
  assign drive = ~oe_n;

  // R3: no rise, latch closed -> stored word steady
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !bclk_rise) |=> $stable(store_q));
  // R4: enabled edge loads the input
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && bclk_rise && !ce_n) |=> store_q == $past(din));
  // R5: gated edge leaves store alone
  a_r5_gated_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && bclk_rise && ce_n) |=> $stable(store_q));
  // R6: store follows input while open
  a_r6_track_open: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> store_q == $past(din));
endmodule

// File: rtl/ubt_transceiver.sv
module ubt_transceiver
  import ubt_pkg::*;
#(
  parameter int W      = UBT_WIDTH,
  parameter int STAGES = UBT_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         le_ab,
  input  logic         clk_ab,
  input  logic         ce_ab_n,
  input  logic         oe_ab_n,
  input  logic         le_ba,
  input  logic         clk_ba,
  input  logic         ce_ba_n,
  input  logic         oe_ba_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  ubt_path #(.W(W), .STAGES(STAGES)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (a_in),
    .le    (le_ab),
    .bclk  (clk_ab),
    .ce_n  (ce_ab_n),
    .oe_n  (oe_ab_n),
    .dout  (b_out),
    .drive (b_drive)
  );

  ubt_path #(.W(W), .STAGES(STAGES)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (b_in),
    .le    (le_ba),
    .bclk  (clk_ba),
    .ce_n  (ce_ba_n),
    .oe_n  (oe_ba_n),
    .dout  (a_out),
    .drive (a_drive)
  );

  // R9: closed A-to-B path with quiet clock keeps B output steady
  a_r9_ab_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !$past(le_ab) && $stable(clk_ab) && $past(clk_ab) == clk_ab && !clk_ab
     && $past(rst_n)) |=> $stable(b_out) || le_ab);
endmodule

// File: tb/ubt_transceiver_test.sv
module ubt_transceiver_test;
  localparam int W = 18;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] din [2];
  logic le [2], bclk [2], ce_n [2], oe_n [2];
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;
  logic [W-1:0] st [2];
  int vectors = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_transceiver uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(din[0]), .b_in(din[1]),
    .le_ab(le[0]), .clk_ab(bclk[0]), .ce_ab_n(ce_n[0]), .oe_ab_n(oe_n[0]),
    .le_ba(le[1]), .clk_ba(bclk[1]), .ce_ba_n(ce_n[1]), .oe_ba_n(oe_n[1]),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  function automatic logic [W-1:0] want_word(input logic open_l,
                                             input logic [W-1:0] live,
                                             input logic [W-1:0] kept);
    if (open_l) return live;
    return kept;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] out_of(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic drv_of(input int d);
    return (d == 0) ? b_drive : a_drive;
  endfunction

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int d = 0; d < 2; d++) begin
      check(tag, out_of(d), want_word(le[d], din[d], st[d]));
      check(tag, {{(W-1){1'b0}}, drv_of(d)}, {{(W-1){1'b0}}, ~oe_n[d]});
    end
  endtask

  task automatic pulse_clock(input int d);
    bclk[d] = 1'b1;
    if (!le[d] && !ce_n[d]) st[d] = din[d];
    settle();
    bclk[d] = 1'b0;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      din[d] = '0; le[d] = 1'b0; bclk[d] = 1'b0; ce_n[d] = 1'b0; oe_n[d] = 1'b0; st[d] = '0;
    end
    din[0] = 18'h2AAAA; din[1] = 18'h15555;
    repeat (4) @(negedge clk);
    check("R1 reset b_out", b_out, '0);
    check("R1 reset a_out", a_out, '0);
    rst_n = 1'b1;
    settle();
    check("R1 after reset b_out", b_out, '0);
    check("R1 after reset a_out", a_out, '0);

    // R2: same-cycle transparency
    din[0] = 18'h1F0F0; le[0] = 1'b1; #1;
    check("R2 transparent", b_out, 18'h1F0F0);
    @(negedge clk); din[0] = 18'h00F3C; #1;
    check("R2 transparent follow", b_out, 18'h00F3C);
    settle(); st[0] = din[0];
    // R6: close the latch, keep last passed word
    le[0] = 1'b0; settle();
    din[0] = 18'h3FFFF; settle();
    check("R6 closed keeps", b_out, 18'h00F3C);
    check("R3 hold static clock", b_out, 18'h00F3C);
    // R4: enabled edge
    pulse_clock(0);
    check("R4 capture", b_out, 18'h3FFFF);
    // R10: falling edge ignored
    din[0] = 18'h12345; bclk[0] = 1'b1; settle(); st[0] = 18'h12345;
    din[0] = 18'h0ABCD; bclk[0] = 1'b0; settle();
    check("R10 falling edge", b_out, 18'h12345);
    // R5: gated edge
    ce_n[0] = 1'b1; pulse_clock(0);
    check("R5 gated edge", b_out, 18'h12345);
    ce_n[0] = 1'b0;
    // R7 / R8
    oe_n[0] = 1'b1; #1;
    check("R7 high impedance", {{(W-1){1'b0}}, b_drive}, '0);
    pulse_clock(0);
    oe_n[0] = 1'b0; #1;
    check("R7 drive back", {{(W-1){1'b0}}, b_drive}, 1);
    check("R8 re-enabled shows store", b_out, 18'h0ABCD);
    check("R9 other path untouched", a_out, '0);
    // R9: mirror direction leaves A-to-B alone
    din[1] = 18'h2B00B; le[1] = 1'b1; #1;
    check("R9 mirror transparent", a_out, 18'h2B00B);
    settle(); st[1] = din[1]; le[1] = 1'b0; settle();
    din[1] = 18'h0C0DE; pulse_clock(1);
    check("R9 mirror capture", a_out, 18'h0C0DE);
    check("R9 A-to-B unchanged", b_out, 18'h0ABCD);

    void'($urandom(32'h5EED1));
    for (int i = 0; i < 400; i++) begin
      int d = int'($urandom_range(0, 1));
      int op = int'($urandom_range(0, 3));
      case (op)
        0: begin din[d] = W'($urandom); settle(); if (le[d]) st[d] = din[d]; end
        1: begin le[d] = ~le[d]; settle(); if (le[d]) st[d] = din[d]; end
        2: begin ce_n[d] = 1'($urandom); pulse_clock(d); end
        default: begin oe_n[d] = 1'($urandom); settle(); end
      endcase
      check_all("R2 R3 R4 R5 R7 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule